// File: doc/BRIEF.md
# Integer ALU with Bit-Field Operations

This block is the 32-bit integer execution stage of a simple scalar core. Each cycle it takes an operation code and a first operand. The second operand is either a register value or a 16-bit constant, selected by a flag. It also takes a bit position and a field length. It returns a result word, a write-enable for the destination, an overflow-trap flag and an illegal-field flag. All four outputs are registered, so a result appears on the clock edge after its inputs.

The operations cover several groups:
- bitwise logic;
- addition and subtraction, each in a form that traps on signed overflow and a form that wraps silently;
- signed and unsigned less-than compares;
- counts of leading ones and leading zeros;
- a byte swap inside each halfword;
- bit-field extract and insert;
- two conditional moves.

An insert merges a field into the old destination value, and that old value arrives on the second operand. A conditional move uses the second operand as its test value and passes the first operand through. Shifts, memory access and multiply/divide belong to other units.

Top module: `bitfield_alu`

## Requirements
- R1: While `rst` is high, all outputs become zero on each rising edge. After reset, every output reflects the inputs sampled at the previous rising edge, which is one cycle of latency.
- R2: Op codes 0, 1, 2 and 3 return a&b, a|b, a^b and ~(a|b). When `imm_sel_i` is 1, these four ops use the 16-bit constant zero-extended as b.
- R3: Op 4 (trapping add) and op 6 (trapping subtract) set `ovf_o` on signed overflow and then drop `wr_en_o`. Op 5 (wrapping add) and op 7 (wrapping subtract) never set `ovf_o`. All four return the wrapped 32-bit sum or difference.
- R4: When `imm_sel_i` is 1, every op other than 0 to 3 uses the 16-bit constant sign-extended to 32 bits as b.
- R5: Op 8 returns 1 if a < b as signed numbers and 0 otherwise. Op 9 does the same compare as unsigned, and this includes a sign-extended constant.
- R6: Op 10 returns the number of consecutive ones from bit 31 downward. Op 11 returns the number of consecutive zeros from bit 31 downward. Each count is 32 for an input that is all ones or all zeros respectively.
- R7: Op 12 returns the bytes of a in the order a[23:16], a[31:24], a[7:0], a[15:8], from most significant to least significant.
- R8: Op 13 returns a[pos+len-1:pos] right-justified and zero-extended. `pos` is `fpos_i` and `len` is `flen_i`.
- R9: Op 14 returns b with bits pos+len-1..pos replaced by a[len-1:0]. All other bits of b are kept.
- R10: Op 15 raises `wr_en_o` only when b is nonzero. Op 16 raises `wr_en_o` only when b is zero. Both return a as the result.
- R11: For ops 13 and 14, a field with len = 0 or pos+len > 32 sets `bad_field_o`, clears the result and drops `wr_en_o`. No other op sets `bad_field_o`.
- R12: Op codes 17 to 31 return 0 with `wr_en_o`, `ovf_o` and `bad_field_o` low. Every other op without a trap, a failed move test or a bad field raises `wr_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand, old destination for an insert, or test value for a move |
| imm_i | input | 16 | Constant operand |
| imm_sel_i | input | 1 | Use the constant in place of `src_b_i` |
| fpos_i | input | 5 | Field start bit |
| flen_i | input | 6 | Field length in bits |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write-enable |
| ovf_o | output | 1 | Signed overflow trap |
| bad_field_o | output | 1 | Illegal extract/insert field |

## Verification
The bench targets the overflow boundaries 0x7FFFFFFF+1 and 0x80000000-1 in both trapping and wrapping forms. A design that mixed up the two forms would trap on wrapping ops or let an overflowed result write. It feeds a constant with bit 15 set to both logic and compare ops. A design that used the wrong extension would produce a wrong OR mask or a wrong unsigned compare. It covers leading counts of all-ones and all-zeros inputs, where a count that stops at 31 shows up. It also covers full-width fields, fields ending exactly at bit 31, and fields one bit past bit 31. These catch mask arithmetic that wraps, or a legality check that is off by one.

// File: rtl/bfalu_pkg.sv
package bfalu_pkg;
  typedef enum logic [4:0] {
    OP_AND        = 5'd0,
    OP_OR         = 5'd1,
    OP_XOR        = 5'd2,
    OP_NOR        = 5'd3,
    OP_ADD_TRAP   = 5'd4,
    OP_ADD_WRAP   = 5'd5,
    OP_SUB_TRAP   = 5'd6,
    OP_SUB_WRAP   = 5'd7,
    OP_LT_S       = 5'd8,
    OP_LT_U       = 5'd9,
    OP_CNT_ONES   = 5'd10,
    OP_CNT_ZEROS  = 5'd11,
    OP_HSWAP      = 5'd12,
    OP_FEXT       = 5'd13,
    OP_FINS       = 5'd14,
    OP_MOV_IF_NZ  = 5'd15,
    OP_MOV_IF_Z   = 5'd16
  } op_e;
endpackage

// File: rtl/bfalu_operand.sv
module bfalu_operand
  import bfalu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  op_e           op,
  input  logic [W-1:0]  b_reg,
  input  logic [IW-1:0] imm,
  input  logic          imm_sel,
  output logic [W-1:0]  b_eff
);
  logic is_logic;
  logic [W-1:0] imm_ext;

  always_comb begin
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    if (is_logic) imm_ext = {{(W-IW){1'b0}}, imm};
    else          imm_ext = {{(W-IW){imm[IW-1]}}, imm};
    b_eff = imm_sel ? imm_ext : b_reg;
  end
endmodule

// File: rtl/bfalu_arith.sv
module bfalu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         ovf_add,
  output logic         ovf_sub,
  output logic         lt_s,
  output logic         lt_u
);
  always_comb begin
    sum     = a + b;
    diff    = a - b;
    ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    ovf_sub = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
    lt_s    = $signed(a) < $signed(b);
    lt_u    = a < b;
  end
endmodule

// File: rtl/bfalu_count.sv
module bfalu_count #(
  parameter int W  = 32,
  localparam int LW = $clog2(W) + 1
) (
  input  logic [W-1:0]  x,
  output logic [LW-1:0] cnt
);
  logic hit;

  always_comb begin
    cnt = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (x[i]) hit = 1'b1;
        else      cnt = cnt + LW'(1);
      end
    end
  end
endmodule

// File: rtl/bfalu_field.sv
module bfalu_field #(
  parameter int W  = 32,
  localparam int PW = $clog2(W),
  localparam int LW = PW + 1,
  localparam int NH = W / 16
) (
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  dst,
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  ext_res,
  output logic [W-1:0]  ins_res,
  output logic [W-1:0]  swap_res,
  output logic          bad
);
  logic [W-1:0]  len_mask;
  logic [W-1:0]  fld_mask;
  logic [LW-1:0] shamt;
  logic [LW:0]   end_pos;

  always_comb begin
    shamt    = LW'(W) - len;
    len_mask = {W{1'b1}} >> shamt;
    fld_mask = len_mask << pos;
    end_pos  = (LW+1)'(pos) + (LW+1)'(len);
    bad      = (len == '0) || (end_pos > (LW+1)'(W));
    ext_res  = (src >> pos) & len_mask;
    ins_res  = (dst & ~fld_mask) | ((src << pos) & fld_mask);
  end

  for (genvar h = 0; h < NH; h++) begin : g_hswap
    assign swap_res[h*16 +: 16] = {src[h*16 +: 8], src[h*16 + 8 +: 8]};
  end
endmodule

// File: rtl/bitfield_alu.sv
module bitfield_alu
  import bfalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  localparam int PW   = $clog2(W),
  localparam int LW   = PW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       op_i,
  input  logic [W-1:0]     src_a_i,
  input  logic [W-1:0]     src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             imm_sel_i,
  input  logic [PW-1:0]    fpos_i,
  input  logic [LW-1:0]    flen_i,
  output logic [W-1:0]     result_o,
  output logic             wr_en_o,
  output logic             ovf_o,
  output logic             bad_field_o
);
  op_e          op;
  logic [W-1:0] b_eff, sum, diff, ext_res, ins_res, swap_res;
  logic         ovf_add, ovf_sub, lt_s, lt_u, fbad;
  logic [LW-1:0] lead_cnt [2];
  logic [W-1:0] r_nx;
  logic         we_nx, ov_nx, bad_nx;

  assign op = op_e'(op_i);

  bfalu_operand #(.W(W), .IW(IMM_W)) u_operand (
    .op(op), .b_reg(src_b_i), .imm(imm_i), .imm_sel(imm_sel_i), .b_eff(b_eff)
  );

  bfalu_arith #(.W(W)) u_arith (
    .a(src_a_i), .b(b_eff), .sum(sum), .diff(diff),
    .ovf_add(ovf_add), .ovf_sub(ovf_sub), .lt_s(lt_s), .lt_u(lt_u)
  );

  // index 0 counts leading ones (input inverted), index 1 counts leading zeros
  for (genvar g = 0; g < 2; g++) begin : g_lead
    bfalu_count #(.W(W)) u_cnt (
      .x  ((g == 0) ? ~src_a_i : src_a_i),
      .cnt(lead_cnt[g])
    );
  end

  bfalu_field #(.W(W)) u_field (
    .src(src_a_i), .dst(b_eff), .pos(fpos_i), .len(flen_i),
    .ext_res(ext_res), .ins_res(ins_res), .swap_res(swap_res), .bad(fbad)
  );

  always_comb begin
    r_nx   = '0;
    we_nx  = 1'b1;
    ov_nx  = 1'b0;
    bad_nx = 1'b0;
    case (op)
      OP_AND:       r_nx = src_a_i & b_eff;
      OP_OR:        r_nx = src_a_i | b_eff;
      OP_XOR:       r_nx = src_a_i ^ b_eff;
      OP_NOR:       r_nx = ~(src_a_i | b_eff);
      OP_ADD_TRAP:  begin r_nx = sum;  ov_nx = ovf_add; we_nx = !ovf_add; end
      OP_ADD_WRAP:  r_nx = sum;
      OP_SUB_TRAP:  begin r_nx = diff; ov_nx = ovf_sub; we_nx = !ovf_sub; end
      OP_SUB_WRAP:  r_nx = diff;
      OP_LT_S:      r_nx = W'(lt_s);
      OP_LT_U:      r_nx = W'(lt_u);
      OP_CNT_ONES:  r_nx = W'(lead_cnt[0]);
      OP_CNT_ZEROS: r_nx = W'(lead_cnt[1]);
      OP_HSWAP:     r_nx = swap_res;
      OP_FEXT:      begin bad_nx = fbad; we_nx = !fbad; r_nx = fbad ? '0 : ext_res; end
      OP_FINS:      begin bad_nx = fbad; we_nx = !fbad; r_nx = fbad ? '0 : ins_res; end
      OP_MOV_IF_NZ: begin r_nx = src_a_i; we_nx = (b_eff != '0); end
      OP_MOV_IF_Z:  begin r_nx = src_a_i; we_nx = (b_eff == '0); end
      default:      we_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o    <= '0;
      wr_en_o     <= 1'b0;
      ovf_o       <= 1'b0;
      bad_field_o <= 1'b0;
    end else begin
      result_o    <= r_nx;
      wr_en_o     <= we_nx;
      ovf_o       <= ov_nx;
      bad_field_o <= bad_nx;
    end
  end

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) ovf_o |-> !wr_en_o); // R3
  AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> ($past(op_i) == OP_ADD_TRAP || $past(op_i) == OP_SUB_TRAP)); // R3
  AST_LT_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_LT_S || $past(op_i) == OP_LT_U)) |-> (result_o[W-1:1] == '0)); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_CNT_ONES || $past(op_i) == OP_CNT_ZEROS)) |-> (result_o <= W)); // R6
  AST_MOVE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_MOV_IF_NZ || $past(op_i) == OP_MOV_IF_Z)) |-> (result_o == $past(src_a_i))); // R10
  AST_BAD_FIELD_QUIET: assert property (@(posedge clk) disable iff (rst)
    bad_field_o |-> (result_o == '0 && !wr_en_o)); // R11
  AST_BAD_FIELD_SOURCE: assert property (@(posedge clk) disable iff (rst)
    bad_field_o |-> ($past(op_i) == OP_FEXT || $past(op_i) == OP_FINS)); // R11
endmodule

// File: tb/bitfield_alu_tb.sv
`timescale 1ns/1ps
module bitfield_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [15:0] imm = '0;
  logic        sel = 1'b0;
  logic [4:0]  pos = '0;
  logic [5:0]  len = '0;
  logic [31:0] result;
  logic        wr_en, ovf, bad;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct { logic [31:0] r; bit we; bit ov; bit bad; string tag; } exp_t;
  exp_t pend_exp;
  bit   pend = 0;

  always #4 clk = ~clk;

  bitfield_alu u_dut (
    .clk(clk), .rst(rst), .op_i(op), .src_a_i(a), .src_b_i(b), .imm_i(imm),
    .imm_sel_i(sel), .fpos_i(pos), .flen_i(len), .result_o(result),
    .wr_en_o(wr_en), .ovf_o(ovf), .bad_field_o(bad)
  );

  function automatic exp_t model(int o, logic [31:0] x, logic [31:0] y, logic [15:0] k,
                                 bit s, int p, int l);
    exp_t e;
    logic [31:0] yb;
    longint wide;
    int n;
    e.r = 0; e.we = 1; e.ov = 0; e.bad = 0;
    if (s) yb = (o <= 3) ? {16'h0, k} : {{16{k[15]}}, k};
    else   yb = y;
    e.tag = (s && o >= 4) ? "R4" : "R2";
    case (o)
      0: e.r = x & yb;
      1: e.r = x | yb;
      2: e.r = x ^ yb;
      3: e.r = ~(x | yb);
      4, 5, 6, 7: begin
        if (!s) e.tag = "R3";
        if (o < 6) wide = longint'($signed(x)) + longint'($signed(yb));
        else       wide = longint'($signed(x)) - longint'($signed(yb));
        e.r = wide[31:0];
        if ((o == 4 || o == 6) && (wide > 64'sd2147483647 || wide < -64'sd2147483648)) begin
          e.ov = 1; e.we = 0;
        end
      end
      8:  begin if (!s) e.tag = "R5"; e.r = ($signed(x) < $signed(yb)) ? 1 : 0; end
      9:  begin if (!s) e.tag = "R5"; e.r = (x < yb) ? 1 : 0; end
      10, 11: begin
        e.tag = "R6"; n = 0;
        while (n < 32 && x[31-n] == (o == 10)) n++;
        e.r = n;
      end
      12: begin e.tag = "R7"; e.r = {x[23:16], x[31:24], x[7:0], x[15:8]}; end
      13, 14: begin
        e.tag = (o == 13) ? "R8" : "R9";
        if (l == 0 || p + l > 32) begin
          e.tag = "R11"; e.bad = 1; e.we = 0; e.r = 0;
        end else if (o == 13) begin
          for (int q = 0; q < l; q++) e.r[q] = x[p+q];
        end else begin
          e.r = yb;
          for (int q = 0; q < l; q++) e.r[p+q] = x[q];
        end
      end
      15: begin e.tag = "R10"; e.r = x; e.we = (yb != 0); end
      16: begin e.tag = "R10"; e.r = x; e.we = (yb == 0); end
      default: begin e.tag = "R12"; e.we = 0; end
    endcase
    return e;
  endfunction

  task automatic check(exp_t e);
    compared++;
    if (result !== e.r || wr_en !== e.we || ovf !== e.ov || bad !== e.bad) begin
      mismatched++;
      $display("FAIL %s: got r=%h we=%b ov=%b bad=%b expected r=%h we=%b ov=%b bad=%b",
               e.tag, result, wr_en, ovf, bad, e.r, e.we, e.ov, e.bad);
    end
  endtask

  // drive at a falling edge; the previous vector's registered output is compared first (R1 latency)
  task automatic step(int o, logic [31:0] x, logic [31:0] y, logic [15:0] k, bit s, int p, int l);
    @(negedge clk);
    if (pend) check(pend_exp);
    op = o[4:0]; a = x; b = y; imm = k; sel = s; pos = p[4:0]; len = l[5:0];
    pend_exp = model(o, x, y, k, s, p, l);
    pend = 1;
  endtask

  initial begin
    exp_t z;
    z.r = 0; z.we = 0; z.ov = 0; z.bad = 0; z.tag = "R1";
    op = 5'd15; a = 32'hDEAD_BEEF; b = 32'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(z);                                  // R1 reset state
    rst = 1'b0;
    // R2 logic, register and zero-extended constant
    step(0, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0, 0);
    step(1, 32'h1200_0000, 0, 16'h8001, 1, 0, 0);
    step(2, 32'hFFFF_0000, 32'h00FF_00FF, 0, 0, 0, 0);
    step(3, 32'h0000_00F0, 32'h0F00_0000, 0, 0, 0, 0);
    step(0, 32'hFFFF_FFFF, 0, 16'hFFFF, 1, 0, 0);
    // R3 trapping versus wrapping at the overflow boundaries
    step(4, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0);
    step(5, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0);
    step(6, 32'h8000_0000, 32'h1, 0, 0, 0, 0);
    step(7, 32'h8000_0000, 32'h1, 0, 0, 0, 0);
    step(4, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0);
    step(4, 32'h7FFF_FFFE, 32'h1, 0, 0, 0, 0);
    // R4 sign-extended constant
    step(4, 32'h5, 0, 16'hFFFF, 1, 0, 0);
    step(9, 32'h5, 0, 16'hFFFF, 1, 0, 0);
    step(8, 32'h5, 0, 16'hFFFF, 1, 0, 0);
    // R5 compares
    step(8, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0);
    step(9, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0);
    step(8, 32'h3, 32'h3, 0, 0, 0, 0);
    // R6 leading counts
    step(10, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step(10, 32'hF000_0000, 0, 0, 0, 0, 0);
    step(11, 32'h0, 0, 0, 0, 0, 0);
    step(11, 32'h1, 0, 0, 0, 0, 0);
    step(11, 32'h8000_0000, 0, 0, 0, 0, 0);
    // R7 halfword byte swap
    step(12, 32'h1122_3344, 0, 0, 0, 0, 0);
    // R8 extract
    step(13, 32'hABCD_EF12, 0, 0, 0, 4, 8);
    step(13, 32'hABCD_EF12, 0, 0, 0, 0, 32);
    step(13, 32'h8000_0000, 0, 0, 0, 31, 1);
    // R9 insert
    step(14, 32'h5, 32'hFFFF_FFFF, 0, 0, 8, 4);
    step(14, 32'h1234_5678, 32'h0, 0, 0, 0, 32);
    step(14, 32'hFFFF_FFFF, 32'h0, 0, 0, 24, 8);
    // R11 illegal fields
    step(13, 32'hFFFF_FFFF, 0, 0, 0, 30, 3);
    step(14, 32'hFFFF_FFFF, 32'h1, 0, 0, 5, 0);
    step(13, 32'hFFFF_FFFF, 0, 0, 0, 1, 32);
    // R10 conditional moves
    step(15, 32'hCAFE_0001, 32'h0, 0, 0, 0, 0);
    step(15, 32'hCAFE_0002, 32'h3, 0, 0, 0, 0);
    step(16, 32'hCAFE_0003, 32'h0, 0, 0, 0, 0);
    step(16, 32'hCAFE_0004, 32'h8000_0000, 0, 0, 0, 0);
    // R12 unused codes
    step(17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 8);
    step(31, 32'h1, 32'h1, 0, 0, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      if ($urandom_range(0, 7) == 0) ra = {ra[31], {31{~ra[31]}}};
      step($urandom_range(0, 18), ra, rb, 16'($urandom), bit'($urandom_range(0, 1)),
           $urandom_range(0, 31), $urandom_range(0, 33));
    end
    @(negedge clk);
    if (pend) check(pend_exp);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule